// File: doc/BRIEF.md
# Configuration Status Interrupt Monitor

The monitor watches a vector of twelve configuration status inputs and turns selected conditions on them into one interrupt line. Each input passes through a two-flop synchroniser. For each bit, software picks level or edge detection, the active polarity, whether the bit may contribute at all (enable) and whether it is currently hidden (mask). A single-cycle address/data bus gives read access to the live synchronised inputs, the raw detection status and the masked status. A write-one-to-clear register acknowledges latched edge events.

Level sources report their active condition as long as it lasts, so acknowledging one has no lasting effect while the condition holds. Edge sources latch on the selected transition and hold until cleared. The interrupt is the OR of all bits that are raw-active, enabled and unmasked. The block does not interpret what any status bit means.

Register offsets (byte addresses, read data zero-extended to 32 bits): 0x00 live inputs (RO), 0x04 raw status (RO), 0x08 masked status (RO), 0x0C acknowledge (WO, reads 0), 0x10 enable, 0x14 mask, 0x18 detect type, 0x1C polarity. Bit n of every register belongs to input n.

Top module: `cfg_status_irq_mon`

## Requirements
- R1: After reset, irq_o is 0 and the enable, mask, type and polarity registers read 0.
- R2: Offset 0x00 returns the synchronised input levels in bits 11:0 and 0 in bits 31:12. A change on status_i is visible there after two rising clock edges.
- R3: A source with type bit 0 (level) and polarity bit 1 shows raw status 1 exactly while its input is high.
- R4: A source with type bit 0 and polarity bit 0 shows raw status 1 exactly while its input is low.
- R5: Writing 1 to a level source's bit at offset 0x0C leaves its raw status at 1 while the condition persists. The raw bit returns to 0 once the condition goes away.
- R6: A source with type bit 1 and polarity bit 1 latches raw status 1 on a rising input and holds it after the input falls. Writing 1 to that bit at 0x0C clears it.
- R7: A source with type bit 1 and polarity bit 0 latches on a falling input and ignores a rising one.
- R8: Offset 0x08 reads raw AND enable AND NOT mask. irq_o is 1 exactly when that value is non-zero.
- R9: A mask bit of 1 keeps its source off irq_o. An enable value of 0 keeps irq_o at 0 whatever the raw status.
- R10: Writes to offsets 0x00, 0x04, 0x08 and to unmapped offsets change no register, and unmapped offsets read 0. Configuration registers keep only bits 11:0.
- R11: A raw status change appears on the third rising edge after the input change: two synchroniser stages plus the detection register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_i | input | 12 | Asynchronous configuration status inputs |
| addr_i | input | 8 | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe, applied at the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt, OR of the masked status |

## Verification
The bench builds the block with its defaults: twelve sources, two synchroniser stages, an 8-bit address and a 32-bit data bus. With those values, the upper data bits beyond the twelve-bit fields are open to checks that they read zero and drop written ones. The three-edge input-to-raw latency can be checked cycle by cycle. Every source bit can be driven separately, so one pattern can mix active and inactive bits under both polarities and both detection types.

// File: rtl/cfgmon_pkg.sv
package cfgmon_pkg;
  localparam int unsigned OFF_LIVE   = 'h00;
  localparam int unsigned OFF_RAW    = 'h04;
  localparam int unsigned OFF_MASKED = 'h08;
  localparam int unsigned OFF_ACK    = 'h0C;
  localparam int unsigned OFF_EN     = 'h10;
  localparam int unsigned OFF_MASK   = 'h14;
  localparam int unsigned OFF_TYPE   = 'h18;
  localparam int unsigned OFF_POL    = 'h1C;
endpackage

// File: rtl/cfgmon_sync.sv
module cfgmon_sync #(
  parameter int unsigned W      = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfgmon_detect.sv
module cfgmon_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic edge_mode_i,
  input  logic pol_i,
  input  logic ack_i,
  output logic raw_o
);
  logic prev_q, raw_q, active, hit;

  assign active = (sync_i == pol_i);
  // transition toward the active level
  assign hit    = active && (sync_i != prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      prev_q <= sync_i;
      if (!edge_mode_i) raw_q <= active;
      else if (hit)     raw_q <= 1'b1;
      else if (ack_i)   raw_q <= 1'b0;
    end
  end

  assign raw_o = raw_q;

  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(raw_q) && $past(edge_mode_i)) |-> ($past(sync_i) != $past(prev_q))); // R6
  AST_EDGE_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && ack_i && !(sync_i == pol_i && sync_i != prev_q)) |=> !raw_q); // R6
endmodule

// File: rtl/cfgmon_regs.sv
module cfgmon_regs
  import cfgmon_pkg::*;
#(
  parameter int unsigned N      = 12,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      live_i,
  input  logic [N-1:0]      raw_i,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      type_o,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      ack_o,
  output logic [N-1:0]      masked_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [N-1:0] en_q, mask_q, type_q, pol_q, wfield;
  logic hit_en, hit_mask, hit_type, hit_pol, cfg_hit;

  assign wfield   = wdata_i[N-1:0];
  assign hit_en   = (addr_i == ADDR_W'(OFF_EN));
  assign hit_mask = (addr_i == ADDR_W'(OFF_MASK));
  assign hit_type = (addr_i == ADDR_W'(OFF_TYPE));
  assign hit_pol  = (addr_i == ADDR_W'(OFF_POL));
  assign cfg_hit  = hit_en | hit_mask | hit_type | hit_pol;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mask_q <= '0;
      type_q <= '0;
      pol_q  <= '0;
    end else if (wr_en_i) begin
      if (hit_en)   en_q   <= wfield;
      if (hit_mask) mask_q <= wfield;
      if (hit_type) type_q <= wfield;
      if (hit_pol)  pol_q  <= wfield;
    end
  end

  assign ack_o    = (wr_en_i && addr_i == ADDR_W'(OFF_ACK)) ? wfield : '0;
  assign masked_o = raw_i & en_q & ~mask_q;
  assign en_o     = en_q;
  assign mask_o   = mask_q;
  assign type_o   = type_q;
  assign pol_o    = pol_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(OFF_LIVE):   rdata_o[N-1:0] = live_i;
      ADDR_W'(OFF_RAW):    rdata_o[N-1:0] = raw_i;
      ADDR_W'(OFF_MASKED): rdata_o[N-1:0] = masked_o;
      ADDR_W'(OFF_EN):     rdata_o[N-1:0] = en_q;
      ADDR_W'(OFF_MASK):   rdata_o[N-1:0] = mask_q;
      ADDR_W'(OFF_TYPE):   rdata_o[N-1:0] = type_q;
      ADDR_W'(OFF_POL):    rdata_o[N-1:0] = pol_q;
      default:             rdata_o = '0;
    endcase
  end

  AST_RO_NO_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !cfg_hit) |=> ($stable(en_q) && $stable(mask_q) && $stable(type_q) && $stable(pol_q))); // R10
endmodule

// File: rtl/cfg_status_irq_mon.sv
module cfg_status_irq_mon #(
  parameter int unsigned N_SRC       = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  status_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [N_SRC-1:0] live, raw, en, mask, typ, pol, ack, masked;

  cfgmon_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(status_i), .q_o(live)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    cfgmon_detect u_det (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sync_i     (live[i]),
      .edge_mode_i(typ[i]),
      .pol_i      (pol[i]),
      .ack_i      (ack[i]),
      .raw_o      (raw[i])
    );
  end

  cfgmon_regs #(.N(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .live_i  (live),
    .raw_i   (raw),
    .en_o    (en),
    .mask_o  (mask),
    .type_o  (typ),
    .pol_o   (pol),
    .ack_o   (ack),
    .masked_o(masked),
    .rdata_o (rdata_o)
  );

  assign irq_o = |masked;

  AST_EN_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> !irq_o); // R9
  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw != '0)); // R8
endmodule

// File: tb/cfg_status_irq_mon_tb.sv
module cfg_status_irq_mon_tb;
  localparam logic [7:0] A_LIVE = 8'h00, A_RAW = 8'h04, A_MSK = 8'h08, A_ACK = 8'h0C;
  localparam logic [7:0] A_EN = 8'h10, A_MASK = 8'h14, A_TYPE = 8'h18, A_POL = 8'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] status = '0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfg_status_irq_mon u_dut (
    .clk_i(clk), .rst_ni(rst_n), .status_i(status), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic drive(input logic [11:0] v);
    @(negedge clk);
    status = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(A_EN, d);   chk("R1 enable", d, 32'h0);
    rd(A_MASK, d); chk("R1 mask", d, 32'h0);
    rd(A_TYPE, d); chk("R1 type", d, 32'h0);
    rd(A_POL, d);  chk("R1 polarity", d, 32'h0);
  endtask

  task automatic t_live();
    logic [31:0] d;
    drive(12'hA5C);
    rd(A_LIVE, d); chk("R2 live", d, 32'h0000_0A5C);
    wr(A_POL, 32'hFFFF_FFFF);
    rd(A_POL, d);  chk("R10 cfg width", d, 32'h0000_0FFF);
    drive(12'h000);
  endtask

  task automatic t_latency();
    logic [31:0] d;
    wr(A_TYPE, 32'h0); wr(A_POL, 32'hFFF);
    drive(12'h000);
    @(negedge clk);
    status = 12'h008;
    addr = A_LIVE;
    @(posedge clk); @(posedge clk); #1;
    chk("R2 live after two edges", rdata, 32'h008);
    rd(A_RAW, d); chk("R11 raw not yet", d, 32'h0);
    @(posedge clk); #1;
    rd(A_RAW, d); chk("R11 raw on third edge", d, 32'h008);
    drive(12'h000);
  endtask

  task automatic t_level_high();
    logic [31:0] d;
    drive(12'h001);
    rd(A_RAW, d); chk("R3 level high active", d, 32'h001);
    drive(12'h000);
    rd(A_RAW, d); chk("R3 level high released", d, 32'h0);
  endtask

  task automatic t_level_low();
    logic [31:0] d;
    wr(A_POL, 32'h0);
    drive(12'hFFE);
    rd(A_RAW, d); chk("R4 level low active", d, 32'h001);
    drive(12'hFFF);
    rd(A_RAW, d); chk("R4 level low released", d, 32'h0);
  endtask

  task automatic t_level_ack();
    logic [31:0] d;
    wr(A_POL, 32'hFFF);
    drive(12'h010);
    wr(A_ACK, 32'h010);
    @(negedge clk);
    rd(A_RAW, d); chk("R5 level persists after ack", d, 32'h010);
    drive(12'h000);
    rd(A_RAW, d); chk("R5 level clears with condition", d, 32'h0);
  endtask

  task automatic t_edge_rise();
    logic [31:0] d;
    wr(A_TYPE, 32'hFFF);
    drive(12'h020);
    rd(A_RAW, d); chk("R6 rising latched", d, 32'h020);
    drive(12'h000);
    rd(A_RAW, d); chk("R6 held after fall", d, 32'h020);
    wr(A_ACK, 32'h020);
    @(negedge clk);
    rd(A_RAW, d); chk("R6 ack clears", d, 32'h0);
  endtask

  task automatic t_edge_fall();
    logic [31:0] d;
    wr(A_POL, 32'h0);
    drive(12'h040);
    rd(A_RAW, d); chk("R7 rising ignored", d, 32'h0);
    drive(12'h000);
    rd(A_RAW, d); chk("R7 falling latched", d, 32'h040);
    wr(A_ACK, 32'h040);
    @(negedge clk);
    rd(A_RAW, d); chk("R7 ack clears", d, 32'h0);
  endtask

  task automatic t_mask_en();
    logic [31:0] d;
    wr(A_POL, 32'hFFF);
    drive(12'h081);
    rd(A_RAW, d); chk("R8 raw", d, 32'h081);
    chk("R9 enable 0 irq", {31'b0, irq}, 32'h0);
    rd(A_MSK, d); chk("R8 masked with enable 0", d, 32'h0);
    wr(A_EN, 32'h001);
    rd(A_MSK, d); chk("R8 masked one enabled", d, 32'h001);
    chk("R8 irq on", {31'b0, irq}, 32'h1);
    wr(A_MASK, 32'h001);
    rd(A_MSK, d); chk("R9 masked bit hidden", d, 32'h0);
    chk("R9 irq masked", {31'b0, irq}, 32'h0);
    wr(A_EN, 32'hFFF);
    rd(A_MSK, d); chk("R8 masked all enabled", d, 32'h080);
    chk("R8 irq other bit", {31'b0, irq}, 32'h1);
    wr(A_EN, 32'h0);
    chk("R9 enable cleared irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    wr(A_LIVE, 32'hFFF); wr(A_RAW, 32'hFFF); wr(A_MSK, 32'hFFF); wr(8'h3C, 32'hFFF);
    rd(A_EN, d);   chk("R10 enable kept", d, 32'h0);
    rd(A_MASK, d); chk("R10 mask kept", d, 32'h001);
    rd(A_TYPE, d); chk("R10 type kept", d, 32'hFFF);
    rd(A_POL, d);  chk("R10 polarity kept", d, 32'hFFF);
    rd(A_RAW, d);  chk("R10 raw kept", d, 32'h081);
    rd(8'h3C, d);  chk("R10 unmapped reads 0", d, 32'h0);
    rd(A_ACK, d);  chk("R10 ack reads 0", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_live();
    t_latency();
    t_level_high();
    t_level_low();
    t_level_ack();
    t_edge_rise();
    t_edge_fall();
    t_mask_en();
    t_readonly();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule